// File: doc/BRIEF.md
# Big-Endian Word Load/Store Port

This block connects the load/store stage of a processor core to a data memory organised in bytes. For each request it takes a base register value and a 16-bit signed displacement, adds them to form a byte address, and checks that the address is word aligned. A store splits the 32-bit data word into four byte lanes, most significant byte first, and writes them into four byte-wide banks that together hold one word per row. A load reads the four lanes of the addressed row and joins them back into a word.

The banks are read without a clock, so a load returns its word in the cycle of the request. Stores commit on the rising clock edge. A request whose address is not a multiple of four writes nothing. It raises an error flag for one cycle. The per-lane write enables and write bytes are brought out, so the order of bytes in memory can be seen at the pins.

Top module: `be_word_port`

## Requirements
- R1: `eff_addr` equals `base_addr` plus `offset` sign-extended from 16 to 32 bits, modulo 2^32, in the same cycle.
- R2: A valid store (`cmd_valid`=1, `cmd_store`=1) whose `eff_addr[1:0]` is 00 drives `lane_we` to 4'b1111 in that cycle and writes all four bytes at the next rising edge.
- R3: Big-endian lanes: byte lane k (`lane_byte[8k+7:8k]`, k=0..3) carries the byte stored at address a+k, which is `wdata[31-8k:24-8k]`. Lane 0 holds the most significant byte.
- R4: `rdata` is the word at the row addressed by `eff_addr` in the same cycle. A load after a store to the same address returns the stored word unchanged.
- R5: A request with `eff_addr[1:0]` not 00 writes nothing: `lane_we` stays 0 and the addressed word keeps its old value.
- R6: `addr_err` is 0 after reset. It is 1 in exactly the cycle after a valid request with `eff_addr[1:0]` not 00, and 0 otherwise.
- R7: Word index i of an array at base b sits at byte address b+4*i. Every word row holds its own value independently of the others.
- R8: Only address bits [ADDR_W-1:2] select the row (ADDR_W=8 by default, 64 words). Higher address bits are ignored, so addresses that differ only above bit ADDR_W-1 reach the same word.
- R9: With `cmd_valid`=0, or with `cmd_store`=0 (a load), `lane_we` is 0 and memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset (error flag only) |
| cmd_valid | input | 1 | Request present this cycle |
| cmd_store | input | 1 | 1 = store word, 0 = load word |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement from the instruction |
| wdata | input | 32 | Store data word |
| rdata | output | 32 | Load data word (same cycle) |
| eff_addr | output | 32 | Computed byte address |
| lane_we | output | 4 | Per-lane bank write enables |
| lane_byte | output | 32 | Per-lane write bytes, lane k in bits [8k+7:8k] |
| addr_err | output | 1 | Registered misalignment flag |

## Verification
`eff_addr`, `rdata`, `lane_we` and `lane_byte` are combinational. They are due in the cycle of the request, so the bench drives inputs on the falling edge and samples one time unit later, before the next rising edge. A stored word becomes readable only after the rising edge that ends the store cycle, so every read-back is issued in a later cycle. `addr_err` passes through one register and is sampled just after the falling edge that follows the commit edge. The cycle after that is sampled as well, to confirm the flag drops again.

// File: rtl/be_word_pkg.sv
package be_word_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int ALIGN_W = $clog2(LANES);

  // byte at address offset k of a big-endian word (k=0 is the MSB)
  function automatic logic [BYTE_W-1:0] be_lane(input logic [WORD_W-1:0] w, input int k);
    return w[WORD_W-1-BYTE_W*k -: BYTE_W];
  endfunction
endpackage

// File: rtl/be_addr_gen.sv
module be_addr_gen
  import be_word_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] disp,
  output logic [XLEN-1:0]  addr,
  output logic             misaligned
);
  logic [XLEN-1:0] disp_ext;

  always_comb begin
    disp_ext   = {{(XLEN-OFF_W){disp[OFF_W-1]}}, disp};
    addr       = base + disp_ext;
    misaligned = |addr[ALIGN_W-1:0];
  end
endmodule

// File: rtl/be_byte_bank.sv
module be_byte_bank
  import be_word_pkg::*;
#(
  parameter int ROW_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] rbyte
);
  localparam int ROWS = 1 << ROW_W;

  logic [BYTE_W-1:0] store_q [ROWS];

  always_ff @(posedge clk) begin
    if (we) store_q[row] <= wbyte;
  end

  assign rbyte = store_q[row];
endmodule

// File: rtl/be_word_port.sv
module be_word_port
  import be_word_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic                 cmd_store,
  input  logic [XLEN-1:0]      base_addr,
  input  logic [OFF_W-1:0]     offset,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic [XLEN-1:0]      eff_addr,
  output logic [LANES-1:0]     lane_we,
  output logic [WORD_W-1:0]    lane_byte,
  output logic                 addr_err
);
  localparam int ROW_W = ADDR_W - ALIGN_W;

  logic             misal;
  logic             commit;
  logic [ROW_W-1:0] row_sel;

  be_addr_gen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agen (
    .base       (base_addr),
    .disp       (offset),
    .addr       (eff_addr),
    .misaligned (misal)
  );

  assign commit  = cmd_valid & cmd_store & ~misal;
  assign row_sel = eff_addr[ADDR_W-1:ALIGN_W];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BYTE_W-1:0] rd_b;

    assign lane_we[k]                  = commit;
    assign lane_byte[BYTE_W*k +: BYTE_W] = be_lane(wdata, k);

    be_byte_bank #(.ROW_W(ROW_W)) u_bank (
      .clk   (clk),
      .we    (lane_we[k]),
      .row   (row_sel),
      .wbyte (lane_byte[BYTE_W*k +: BYTE_W]),
      .rbyte (rd_b)
    );

    assign rdata[WORD_W-1-BYTE_W*k -: BYTE_W] = rd_b;
  end

  always_ff @(posedge clk) begin
    if (rst) addr_err <= 1'b0;
    else     addr_err <= cmd_valid & misal;
  end

  a_r1_sext_sum: assert property (@(posedge clk) disable iff (rst)
    (eff_addr - base_addr) == XLEN'($signed(offset)));

  a_r3_msb_first: assert property (@(posedge clk) disable iff (rst)
    (lane_we != '0) |-> (lane_byte[BYTE_W-1:0] == wdata[WORD_W-1 -: BYTE_W]));

  a_r5_no_misaligned_write: assert property (@(posedge clk) disable iff (rst)
    (lane_we != '0) |-> (eff_addr[ALIGN_W-1:0] == '0));

  a_r2_all_lanes: assert property (@(posedge clk) disable iff (rst)
    ($countones(lane_we) == 0) || ($countones(lane_we) == LANES));

  a_r6_err_follows: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && eff_addr[ALIGN_W-1:0] != '0) |=> addr_err);

  a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && eff_addr[ALIGN_W-1:0] == '0) |=> !addr_err);

  a_r9_load_no_write: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid || !cmd_store) |-> (lane_we == '0));
endmodule

// File: tb/be_word_port_tb.sv
module be_word_port_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, cmd_store;
  logic [31:0] base_addr;
  logic [15:0] offset;
  logic [31:0] wdata;
  logic [31:0] rdata, eff_addr, lane_byte;
  logic [3:0]  lane_we;
  logic        addr_err;

  int total = 0;
  int bad   = 0;

  be_word_port u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
    .base_addr(base_addr), .offset(offset), .wdata(wdata), .rdata(rdata),
    .eff_addr(eff_addr), .lane_we(lane_we), .lane_byte(lane_byte), .addr_err(addr_err)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    return 32'hA51C_3E70 ^ (32'(i) * 32'h0103_0507);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, settle, leave sampling to caller
  task automatic put(input logic v, input logic s, input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = v; cmd_store = s; base_addr = b; offset = o; wdata = d;
    #1;
  endtask

  task automatic idle();
    put(1'b0, 1'b0, 32'h0, 16'h0, 32'h0);
  endtask

  task automatic load_chk(input logic [31:0] a, input logic [31:0] exp, input string req);
    put(1'b1, 1'b0, a, 16'h0, 32'h0);
    chk(rdata == exp, req, rdata, exp);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 0; cmd_store = 0; base_addr = 0; offset = 0; wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    chk(addr_err == 1'b0, "R6 reset", {31'b0, addr_err}, 32'h0);
    chk(lane_we == 4'h0, "R9 idle", {28'b0, lane_we}, 32'h0);

    // R1 sign extension cases
    put(1'b0, 1'b0, 32'h0000_0100, 16'hFFFC, 0);
    chk(eff_addr == 32'h0000_00FC, "R1 neg", eff_addr, 32'h0000_00FC);
    put(1'b0, 1'b0, 32'h0000_0000, 16'h8000, 0);
    chk(eff_addr == 32'hFFFF_8000, "R1 min", eff_addr, 32'hFFFF_8000);
    put(1'b0, 1'b0, 32'h7FFF_FFFF, 16'h0001, 0);
    chk(eff_addr == 32'h8000_0000, "R1 carry", eff_addr, 32'h8000_0000);
    put(1'b0, 1'b0, 32'h0000_0018, 16'h7FFF, 0);
    chk(eff_addr == 32'h0000_8017, "R1 maxpos", eff_addr, 32'h0000_8017);

    // R7/R2/R3 sweep: word i stored through base 0x80, offset 4*i-128
    for (int i = 0; i < 64; i++) begin
      put(1'b1, 1'b1, 32'h80, 16'(4*i - 128), pat(i));
      chk(eff_addr == 32'(4*i), "R7 index", eff_addr, 32'(4*i));
      chk(lane_we == 4'hF, "R2 we", {28'b0, lane_we}, 32'hF);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] e;
        e = pat(i) >> (24 - 8*k);
        chk(lane_byte[8*k +: 8] == e, "R3 lane", {24'b0, lane_byte[8*k +: 8]}, {24'b0, e});
      end
    end
    for (int i = 0; i < 64; i++) load_chk(32'(4*i), pat(i), "R4 R7 readback");

    // R5/R6 misaligned stores
    for (int m = 1; m < 4; m++) begin
      put(1'b1, 1'b1, 32'h10, 16'(m), 32'hDEAD_BEEF);
      chk(lane_we == 4'h0, "R5 we", {28'b0, lane_we}, 32'h0);
      idle();
      chk(addr_err == 1'b1, "R6 raise", {31'b0, addr_err}, 32'h1);
      idle();
      chk(addr_err == 1'b0, "R6 drop", {31'b0, addr_err}, 32'h0);
      load_chk(32'h10, pat(4), "R5 unchanged");
    end
    // aligned request leaves flag low
    load_chk(32'h14, pat(5), "R4 load");
    idle();
    chk(addr_err == 1'b0, "R6 aligned", {31'b0, addr_err}, 32'h0);

    // R9: invalid store and load do not write
    put(1'b0, 1'b1, 32'h20, 16'h0, 32'h1111_2222);
    chk(lane_we == 4'h0, "R9 novalid", {28'b0, lane_we}, 32'h0);
    put(1'b1, 1'b0, 32'h20, 16'h0, 32'h3333_4444);
    chk(lane_we == 4'h0, "R9 load", {28'b0, lane_we}, 32'h0);
    load_chk(32'h20, pat(8), "R9 unchanged");

    // R8 aliasing above ADDR_W
    put(1'b1, 1'b1, 32'h0000_0100, 16'h0020, 32'h0BAD_F00D);
    load_chk(32'h20, 32'h0BAD_F00D, "R8 alias low");
    load_chk(32'hFFFF_FF20, 32'h0BAD_F00D, "R8 alias high");
    load_chk(32'h24, pat(9), "R8 neighbour");

    // R4 back-to-back store then load, all-ones and zero words
    put(1'b1, 1'b1, 32'hFC, 16'h0, 32'hFFFF_FFFF);
    load_chk(32'hFC, 32'hFFFF_FFFF, "R4 ones");
    put(1'b1, 1'b1, 32'h0, 16'h0, 32'h0);
    load_chk(32'h0, 32'h0, "R4 zero");

    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule